// File: doc/BRIEF.md
# Operating-Mode and Wake-Up Controller

This block tracks the operating mode of a small processor subsystem and brings it back to full speed after a low-power period. Software asks for a low-power mode with a one-cycle request. The block refuses the request when a wake source is already pending. While the system runs, the block can also drop by itself to a low clock gear and climb back when an interrupt arrives. It drives the divide value for the clock generator, a core clock enable, a ready flag for full-speed operation and a one-cycle pulse on every return to full speed.

Wake sources are a level-sensitive request from the interrupt controller, a decrementer exception, and three timer interrupts. Each timer interrupt, when its enable is set, latches a sticky status bit. That bit keeps counting as a pending wake source until software clears it with a write-one-to-clear strobe. The light modes return after a short fixed latency. The deep mode waits out a longer programmable latency. The power-off mode ignores every interrupt and leaves only on the external wake pin, followed by a power-on delay.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: After a synchronous reset: mode is 0 (full speed), `ready` and `core_clk_en` are 1, `wake_pulse`, `req_err` and `tmr_sts` are 0, and `clk_div` equals `div_hi_cfg`.
- R2: A timer bit `tmr_sts[i]` is set one cycle after `tmr_irq[i]` is high while `tmr_en[i]` is high. An interrupt with its enable low sets nothing. A bit clears only one cycle after `sts_clr[i]` is high. If set and clear are high together, set wins.
- R3: Mode codes are 0 full speed, 1 low gear, 2 doze-high, 3 doze-low, 4 sleep, 5 deep-sleep and 6 power-off. In mode 0, with nothing pending, `req_valid` with `req_mode` in 1..6 moves the mode to that code on the next cycle. Codes 0 and 7 are ignored.
- R4: A low-power request made in mode 0 while a wake source is pending (`ictl_req`, `dec_exc` or any `tmr_sts` bit) leaves the mode at 0 and raises `req_err` for exactly one cycle.
- R5: In mode 0 with no request, the block moves to mode 1 on the next cycle when all of these hold: `gear_en` is 1, `pm_en` is 1 and no wake source is pending.
- R6: In modes 1 to 4 a pending wake source starts a wake-up. In mode 1 a low `pm_en` also starts one. The mode reads 0 exactly `WAKE_CYC` cycles after the first edge that sees the source.
- R7: `ictl_req` is level sensitive. While it stays high the block stays at mode 0 and does not drop to the low gear.
- R8: In mode 5 a pending wake source returns the block to mode 0 `DEEP_CYC` cycles after the first edge that sees it. The external pin has no effect in this mode.
- R9: In mode 6 interrupts have no effect. `ext_wake` returns the block to mode 0 `PWRON_CYC` cycles after the first edge that sees it.
- R10: `clk_div` equals `div_lo_cfg` in modes 1 and 3 while `gear_en` is 1. Otherwise it equals `div_hi_cfg`.
- R11: `core_clk_en` is 1 only in modes 0 and 1. `ready` is 1 only in mode 0. `wake_pulse` is 1 for exactly the first cycle of each return to mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at maximum frequency |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Software mode request strobe |
| req_mode | input | 3 | Requested mode code |
| pm_en | input | 1 | Power-management enable |
| gear_en | input | 1 | Automatic gear-switch enable |
| div_lo_cfg | input | DIV_W | Divide value for the low gear |
| div_hi_cfg | input | DIV_W | Divide value for the high gear |
| ictl_req | input | 1 | Level wake request from the interrupt controller |
| tmr_irq | input | N_TMR | Timer interrupt pulses |
| tmr_en | input | N_TMR | Per-timer wake enables |
| sts_clr | input | N_TMR | Write-one-to-clear strobes for timer status |
| dec_exc | input | 1 | Decrementer exception |
| ext_wake | input | 1 | External wake pin |
| tmr_sts | output | N_TMR | Sticky timer status |
| mode_o | output | 3 | Current mode code |
| clk_div | output | DIV_W | Selected clock divide value |
| core_clk_en | output | 1 | Core clock enable |
| ready | output | 1 | Full-speed operation flag |
| wake_pulse | output | 1 | One-cycle pulse on entry to full speed |
| req_err | output | 1 | One-cycle refused-request flag |

## Verification
The bench builds the block with `WAKE_CYC`=3, `DEEP_CYC`=7 and `PWRON_CYC`=5. With these short latencies it can sweep every low-power mode against every wake source, including the external pin and a dropped `pm_en`, and measure each return time to the exact cycle in a few dozen cycles per trial. With `DIV_W`=4 the two divide values can be told apart, and three timer bits are enough to exercise the enable masking, clear, and set-over-clear cases of the sticky status on its own bits.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;
  typedef enum logic [2:0] {
    M_NH = 3'd0,
    M_NL = 3'd1,
    M_DH = 3'd2,
    M_DL = 3'd3,
    M_SL = 3'd4,
    M_DS = 3'd5,
    M_PD = 3'd6
  } pmode_e;

  typedef enum logic {
    PH_RUN = 1'b0,
    PH_CNT = 1'b1
  } phase_e;
endpackage

// File: rtl/pwr_tmr_sticky.sv
module pwr_tmr_sticky #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] irq,
  input  logic [N-1:0] en,
  input  logic [N-1:0] clr,
  output logic [N-1:0] sts
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) sts[i] <= 1'b0;
      else     sts[i] <= (irq[i] & en[i]) | (sts[i] & ~clr[i]);
    end
  end
endmodule

// File: rtl/pwr_lat_cnt.sv
module pwr_lat_cnt #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (ld)          cnt <= ld_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_wake_pkg::*;
#(
  parameter int DIV_W   = 4,
  parameter int CNT_W   = 9,
  parameter int WAKE_V  = 3,
  parameter int DEEP_V  = 480,
  parameter int PWRON_V = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [2:0]       req_mode,
  input  logic             pm_en,
  input  logic             gear_en,
  input  logic [DIV_W-1:0] div_lo_cfg,
  input  logic [DIV_W-1:0] div_hi_cfg,
  input  logic             async_pend,
  input  logic             ext_wake,
  input  logic             cnt_zero,
  output logic             cnt_ld,
  output logic [CNT_W-1:0] cnt_val,
  output logic [2:0]       mode_o,
  output logic [DIV_W-1:0] clk_div,
  output logic             core_clk_en,
  output logic             ready,
  output logic             wake_pulse,
  output logic             req_err
);
  localparam logic [CNT_W-1:0] WAKE_LD  = CNT_W'(WAKE_V - 1);
  localparam logic [CNT_W-1:0] DEEP_LD  = CNT_W'(DEEP_V - 1);
  localparam logic [CNT_W-1:0] PWRON_LD = CNT_W'(PWRON_V - 1);

  pmode_e mode_q, mode_d;
  phase_e ph_q, ph_d;
  logic   err_d;
  logic   req_lp;

  assign req_lp = req_valid && (req_mode != 3'd0) && (req_mode != 3'd7);

  always_comb begin
    mode_d  = mode_q;
    ph_d    = ph_q;
    cnt_ld  = 1'b0;
    cnt_val = '0;
    err_d   = 1'b0;
    if (ph_q == PH_CNT) begin
      if (cnt_zero) begin
        mode_d = M_NH;
        ph_d   = PH_RUN;
      end
    end else begin
      case (mode_q)
        M_NH: begin
          if (req_lp) begin
            if (async_pend) err_d  = 1'b1;
            else            mode_d = pmode_e'(req_mode);
          end else if (gear_en && pm_en && !async_pend) begin
            mode_d = M_NL;
          end
        end
        M_NL: begin
          if (async_pend || !pm_en) begin
            cnt_ld  = 1'b1;
            cnt_val = WAKE_LD;
            ph_d    = PH_CNT;
          end
        end
        M_DH, M_DL, M_SL: begin
          if (async_pend) begin
            cnt_ld  = 1'b1;
            cnt_val = WAKE_LD;
            ph_d    = PH_CNT;
          end
        end
        M_DS: begin
          if (async_pend) begin
            cnt_ld  = 1'b1;
            cnt_val = DEEP_LD;
            ph_d    = PH_CNT;
          end
        end
        M_PD: begin
          if (ext_wake) begin
            cnt_ld  = 1'b1;
            cnt_val = PWRON_LD;
            ph_d    = PH_CNT;
          end
        end
        default: mode_d = M_NH;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= M_NH;
      ph_q        <= PH_RUN;
      clk_div     <= div_hi_cfg;
      core_clk_en <= 1'b1;
      ready       <= 1'b1;
      wake_pulse  <= 1'b0;
      req_err     <= 1'b0;
    end else begin
      mode_q      <= mode_d;
      ph_q        <= ph_d;
      clk_div     <= (gear_en && (mode_d == M_NL || mode_d == M_DL)) ? div_lo_cfg : div_hi_cfg;
      core_clk_en <= (mode_d == M_NH) || (mode_d == M_NL);
      ready       <= (mode_d == M_NH);
      wake_pulse  <= (mode_d == M_NH) && (mode_q != M_NH);
      req_err     <= err_d;
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl #(
  parameter int DIV_W     = 4,
  parameter int N_TMR     = 3,
  parameter int WAKE_CYC  = 3,
  parameter int DEEP_CYC  = 480,
  parameter int PWRON_CYC = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [2:0]       req_mode,
  input  logic             pm_en,
  input  logic             gear_en,
  input  logic [DIV_W-1:0] div_lo_cfg,
  input  logic [DIV_W-1:0] div_hi_cfg,
  input  logic             ictl_req,
  input  logic [N_TMR-1:0] tmr_irq,
  input  logic [N_TMR-1:0] tmr_en,
  input  logic [N_TMR-1:0] sts_clr,
  input  logic             dec_exc,
  input  logic             ext_wake,
  output logic [N_TMR-1:0] tmr_sts,
  output logic [2:0]       mode_o,
  output logic [DIV_W-1:0] clk_div,
  output logic             core_clk_en,
  output logic             ready,
  output logic             wake_pulse,
  output logic             req_err
);
  localparam int MAX_A = (WAKE_CYC > DEEP_CYC) ? WAKE_CYC : DEEP_CYC;
  localparam int MAX_C = (MAX_A > PWRON_CYC) ? MAX_A : PWRON_CYC;
  localparam int CNT_W = $clog2(MAX_C + 1);

  logic             async_pend;
  logic             cnt_ld;
  logic             cnt_zero;
  logic [CNT_W-1:0] cnt_val;

  pwr_tmr_sticky #(.N(N_TMR)) u_sticky (
    .clk (clk),
    .rst (rst),
    .irq (tmr_irq),
    .en  (tmr_en),
    .clr (sts_clr),
    .sts (tmr_sts)
  );

  assign async_pend = ictl_req | dec_exc | (|tmr_sts);

  pwr_lat_cnt #(.W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .ld     (cnt_ld),
    .ld_val (cnt_val),
    .zero   (cnt_zero)
  );

  pwr_mode_fsm #(
    .DIV_W   (DIV_W),
    .CNT_W   (CNT_W),
    .WAKE_V  (WAKE_CYC),
    .DEEP_V  (DEEP_CYC),
    .PWRON_V (PWRON_CYC)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_mode    (req_mode),
    .pm_en       (pm_en),
    .gear_en     (gear_en),
    .div_lo_cfg  (div_lo_cfg),
    .div_hi_cfg  (div_hi_cfg),
    .async_pend  (async_pend),
    .ext_wake    (ext_wake),
    .cnt_zero    (cnt_zero),
    .cnt_ld      (cnt_ld),
    .cnt_val     (cnt_val),
    .mode_o      (mode_o),
    .clk_div     (clk_div),
    .core_clk_en (core_clk_en),
    .ready       (ready),
    .wake_pulse  (wake_pulse),
    .req_err     (req_err)
  );
endmodule

// File: rtl/pwr_wake_chk.sv
module pwr_wake_chk #(
  parameter int N_TMR = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       mode_o,
  input logic             ready,
  input logic             core_clk_en,
  input logic             wake_pulse,
  input logic             req_err,
  input logic [N_TMR-1:0] tmr_sts,
  input logic [N_TMR-1:0] sts_clr
);
  AST_STS_STICKY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((tmr_sts & $past(tmr_sts & ~sts_clr)) == $past(tmr_sts & ~sts_clr))); // R2
  AST_ERR_IN_NH: assert property (@(posedge clk) disable iff (rst)
    req_err |-> (mode_o == 3'd0)); // R4
  AST_WAKE_NH: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |-> (mode_o == 3'd0) && ready && ($past(mode_o) != 3'd0)); // R11
  AST_NH_ENTRY: assert property (@(posedge clk) disable iff (rst)
    ((mode_o == 3'd0) && ($past(mode_o) != 3'd0)) |-> wake_pulse); // R11
  AST_CLKEN_MODE: assert property (@(posedge clk) disable iff (rst)
    core_clk_en |-> (mode_o == 3'd0 || mode_o == 3'd1)); // R11
  AST_PD_EXIT: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd6) |=> (mode_o == 3'd6 || mode_o == 3'd0)); // R9
  AST_DS_EXIT: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd5) |=> (mode_o == 3'd5 || mode_o == 3'd0)); // R8
endmodule

bind pwr_wake_ctrl pwr_wake_chk #(.N_TMR(N_TMR)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .mode_o      (mode_o),
  .ready       (ready),
  .core_clk_en (core_clk_en),
  .wake_pulse  (wake_pulse),
  .req_err     (req_err),
  .tmr_sts     (tmr_sts),
  .sts_clr     (sts_clr)
);

// File: tb/pwr_wake_ctrl_bench.sv
module pwr_wake_ctrl_bench;
  localparam int DIV_W = 4;
  localparam int NT    = 3;
  localparam int WK    = 3;
  localparam int DP    = 7;
  localparam int PO    = 5;
  localparam logic [DIV_W-1:0] DLO = 4'h3;
  localparam logic [DIV_W-1:0] DHI = 4'h9;

  logic clk = 1'b0;
  logic rst;
  logic req_valid;
  logic [2:0] req_mode;
  logic pm_en, gear_en, ictl_req, dec_exc, ext_wake;
  logic [NT-1:0] tmr_irq, tmr_en, sts_clr, tmr_sts;
  logic [2:0] mode_o;
  logic [DIV_W-1:0] clk_div;
  logic core_clk_en, ready, wake_pulse, req_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwr_wake_ctrl #(
    .DIV_W(DIV_W), .N_TMR(NT), .WAKE_CYC(WK), .DEEP_CYC(DP), .PWRON_CYC(PO)
  ) u_pwr_wake_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
    .pm_en(pm_en), .gear_en(gear_en), .div_lo_cfg(DLO), .div_hi_cfg(DHI),
    .ictl_req(ictl_req), .tmr_irq(tmr_irq), .tmr_en(tmr_en), .sts_clr(sts_clr),
    .dec_exc(dec_exc), .ext_wake(ext_wake), .tmr_sts(tmr_sts), .mode_o(mode_o),
    .clk_div(clk_div), .core_clk_en(core_clk_en), .ready(ready),
    .wake_pulse(wake_pulse), .req_err(req_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    req_valid = 1'b0; req_mode = 3'd0; pm_en = 1'b1; gear_en = 1'b0;
    ictl_req = 1'b0; dec_exc = 1'b0; ext_wake = 1'b0;
    tmr_irq = '0; tmr_en = '0; sts_clr = '0;
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic request(input logic [2:0] m);
    req_valid = 1'b1; req_mode = m;
    tick();
    req_valid = 1'b0; req_mode = 3'd0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    check(mode_o == 3'd0, "R1 mode", mode_o, 0);
    check(ready && core_clk_en, "R1 ready/clk_en", {ready, core_clk_en}, 3);
    check(!wake_pulse && !req_err, "R1 pulses", {wake_pulse, req_err}, 0);
    check(tmr_sts == '0, "R1 sts", tmr_sts, 0);
    check(clk_div == DHI, "R1 clk_div", clk_div, DHI);

    // R3 codes 0 and 7 ignored
    request(3'd0);
    check(mode_o == 3'd0, "R3 code0 ignored", mode_o, 0);
    request(3'd7);
    check(mode_o == 3'd0 && !req_err, "R3 code7 ignored", mode_o, 0);

    // R2 enable masking
    tmr_en = '0; tmr_irq = 3'b111;
    tick(); tmr_irq = '0; tick();
    check(tmr_sts == 3'b000, "R2 disabled irq", tmr_sts, 0);
    tmr_en = 3'b010; tmr_irq = 3'b111;
    tick(); tmr_irq = '0;
    check(tmr_sts == 3'b010, "R2 enabled irq", tmr_sts, 2);
    tick();
    check(tmr_sts == 3'b010, "R2 sticky", tmr_sts, 2);

    // R4 refusal with sticky status pending
    request(3'd4);
    check(req_err == 1'b1, "R4 err raised", req_err, 1);
    check(mode_o == 3'd0, "R4 mode kept", mode_o, 0);
    tick();
    check(req_err == 1'b0, "R4 err one cycle", req_err, 0);

    // R2 set wins over clear, then clear
    sts_clr = 3'b010; tmr_irq = 3'b010;
    tick(); tmr_irq = '0;
    check(tmr_sts == 3'b010, "R2 set over clear", tmr_sts, 2);
    tick(); sts_clr = '0;
    check(tmr_sts == 3'b000, "R2 w1c", tmr_sts, 0);

    // R4 refusal with decrementer, then R3 acceptance
    dec_exc = 1'b1;
    request(3'd5);
    check(req_err && mode_o == 3'd0, "R4 dec refuse", mode_o, 0);
    dec_exc = 1'b0;
    request(3'd5);
    check(mode_o == 3'd5 && !req_err, "R3 accept deep", mode_o, 5);

    // R5 / R10 / R7 automatic gear
    do_reset();
    gear_en = 1'b1;
    tick();
    check(mode_o == 3'd1, "R5 gear down", mode_o, 1);
    check(clk_div == DLO, "R10 low div", clk_div, DLO);
    check(core_clk_en && !ready, "R11 low gear flags", {core_clk_en, ready}, 2);
    ictl_req = 1'b1;
    begin
      int n = 0;
      for (int k = 1; k <= 20; k++) begin
        tick();
        if (mode_o == 3'd0) begin n = k; break; end
      end
      check(n == WK + 1, "R6 ictl wake latency", n, WK + 1);
    end
    check(clk_div == DHI, "R10 high div", clk_div, DHI);
    for (int k = 0; k < 5; k++) begin
      tick();
      check(mode_o == 3'd0, "R7 level holds", mode_o, 0);
    end
    ictl_req = 1'b0;
    tick();
    check(mode_o == 3'd1, "R5 gear down again", mode_o, 1);
    gear_en = 1'b0;
    tick();
    check(mode_o == 3'd1 && clk_div == DHI, "R10 gear off div", clk_div, DHI);

    // R10 doze-low with gear enabled, request has priority
    do_reset();
    gear_en = 1'b1;
    request(3'd3);
    check(mode_o == 3'd3, "R3 doze-low entry", mode_o, 3);
    check(clk_div == DLO, "R10 doze-low div", clk_div, DLO);

    // Sweep: every low-power mode against every wake source
    for (int m = 1; m <= 6; m++) begin
      for (int s = 0; s <= 6; s++) begin
        bit    is_async, wk;
        int    base, lat, got;
        string tag;
        is_async = (s <= 4);
        wk = ((m <= 5) && is_async) || (m == 1 && s == 6) || (m == 6 && s == 5);
        base = (m == 5) ? DP : (m == 6) ? PO : WK;
        lat = base + 1 + ((s >= 1 && s <= 3) ? 1 : 0);
        tag = (m <= 4) ? "R6" : (m == 5) ? "R8" : "R9";
        do_reset();
        request(3'(m));
        check(mode_o == 3'(m), "R3 entry", mode_o, m);
        check(core_clk_en == (m == 1), "R11 clk_en", core_clk_en, (m == 1));
        check(!ready, "R11 ready low", ready, 0);
        case (s)
          0: ictl_req = 1'b1;
          1, 2, 3: begin tmr_en = '1; tmr_irq[s-1] = 1'b1; end
          4: dec_exc = 1'b1;
          5: ext_wake = 1'b1;
          default: pm_en = 1'b0;
        endcase
        got = 0;
        for (int k = 1; k <= 40; k++) begin
          tick();
          if (k == 1) tmr_irq = '0;
          if (mode_o == 3'd0) begin got = k; break; end
        end
        if (wk) begin
          check(got == lat, {tag, " wake latency"}, got, lat);
          check(wake_pulse && ready, "R11 wake pulse", wake_pulse, 1);
          tick();
          check(!wake_pulse, "R11 pulse one cycle", wake_pulse, 0);
        end else begin
          check(got == 0 && mode_o == 3'(m), {tag, " source ignored"}, mode_o, m);
        end
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule